// File: doc/BRIEF.md
# Serial Memory Slave Model

This block is a synthesizable SPI slave that acts like a small serial memory. It exists so that a memory master on the same chip can be tested in loopback without an external device. The slave clock, the data input and the active-low select are brought into the system clock domain through two flip-flops each. The block finds the serial clock edges in that domain and drives the data output from a register. An internal byte array holds the contents.

A frame begins when select goes low and ends when it goes high. The first byte is an opcode. A write-enable opcode, sent in a frame of its own, arms a latch. A write or read opcode is followed by the address and then by any number of data bytes. The address steps by one after every data byte and wraps at the array size. A parameter picks how the address is sent. In compressed mode there is one address byte, and address bit 8 travels in bit 3 of the opcode. In wide mode a set number of address bytes arrive with the most significant byte first.

The controller has seven states. IDLE holds while select is high. CMD collects the opcode. WREN means a lone write-enable byte has arrived. ADDR collects the address bytes. WDATA stores bytes into the array. RDATA shifts bytes out. SKIP discards the rest of a frame. The transitions are as follows:
- IDLE goes to CMD when select goes low.
- CMD goes to WREN on the write-enable opcode, to ADDR on a write or read opcode, and to SKIP on any other opcode.
- WREN goes to SKIP on any further serial clock rise.
- ADDR goes to WDATA or RDATA after the last address byte.
- Every state goes to IDLE when select goes high.

Top module: `spi_mem_model`

## Requirements
- R1: After reset the data output is 0 and the write-enable latch is clear, so a write frame sent with no write-enable first leaves the memory unchanged.
- R2: A frame that holds only the byte 0x06 sets the latch when select rises. The write opcode 0x02 then stores data bytes into the array.
- R3: A 0x06 byte followed by further serial clock bits in the same frame does not set the latch.
- R4: A write frame is ignored when the latch is clear. The latch clears at the end of every write frame, so a second write with no new write-enable is ignored.
- R5: Opcode 0x03 returns the stored bytes MSB first in SPI mode 0. Each bit is valid on the output before the rising serial clock edge that would sample it.
- R6: In compressed mode, opcodes 0x0A and 0x0B write and read with address bit 8 set. The single address byte gives bits 7..0. Opcodes 0x02 and 0x03 use bit 8 clear.
- R7: In wide mode, ADDR_BYTES address bytes are taken most significant first. The address is reduced modulo MEM_BYTES.
- R8: The address steps by one after each data byte and wraps from MEM_BYTES-1 to 0, for both reads and writes.
- R9: An unknown opcode makes the slave ignore the rest of the frame. The output stays 0 and the memory is not written. In wide mode, 0x0A and 0x0B count as unknown.
- R10: The data output is 0 whenever select is high and during the command and address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data into the slave |
| cs_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data out of the slave |

## Verification
Two events can land in the same system clock cycle: the store of the last data byte of a write frame and the clearing of the write-enable latch at the end of that frame. The bench provokes this in the wrapping write. It raises select one system clock after the final rising serial clock edge, so the completed byte and the detected select rise reach the controller together. It then judges the outcome at the ports. A read must return that final byte as stored, and a later write with no new write-enable must leave the memory unchanged.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WREN,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } mem_state_t;

    localparam logic [7:0] OP_ARM   = 8'h06;
    localparam logic [7:0] OP_STORE = 8'h02;
    localparam logic [7:0] OP_FETCH = 8'h03;
    localparam logic [7:0] OP_HIBIT = 8'h08;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic s1, s2, s3;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= RST_VAL[g];
                    s2 <= RST_VAL[g];
                    s3 <= RST_VAL[g];
                end else begin
                    s1 <= din[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign dout[g] = s2;
            assign rise[g] = s2 & ~s3;
            assign fall[g] = ~s2 & s3;
        end
    endgenerate

endmodule

// File: rtl/spi_mem_rx.sv
module spi_mem_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       bit_stb,
    input  logic       bit_val,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic       at_bound
);

    logic [2:0] cnt;
    logic [6:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (clear) begin
                cnt <= '0;
                sh  <= '0;
            end else if (bit_stb) begin
                cnt <= cnt + 3'd1;
                sh  <= {sh[5:0], bit_val};
                if (cnt == 3'd7) begin
                    byte_stb <= 1'b1;
                    byte_val <= {sh, bit_val};
                end
            end
        end
    end

    assign at_bound = (cnt == 3'd0);

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_mem_model.sv
module spi_mem_model
    import spi_mem_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int ADDR_BYTES = 2,
    parameter bit NINE_BIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic cs_n,
    output logic miso
);

    localparam int AW    = $clog2(MEM_BYTES);
    localparam int NADDR = NINE_BIT ? 1 : ADDR_BYTES;
    localparam int ACW   = (8 * NADDR + 1 > AW) ? 8 * NADDR + 1 : AW;

    // synchronised inputs: bit 0 serial clock, bit 1 data, bit 2 select
    logic [2:0] s_v, rise_v, fall_v;
    logic       sclk_rise, sclk_fall, mosi_s, cs_s, cs_rise;

    spi_mem_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, mosi, sclk}),
        .dout (s_v),
        .rise (rise_v),
        .fall (fall_v)
    );

    assign sclk_rise = rise_v[0];
    assign sclk_fall = fall_v[0];
    assign mosi_s    = s_v[1];
    assign cs_s      = s_v[2];
    assign cs_rise   = rise_v[2];

    logic       byte_done, at_bound;
    logic [7:0] rx_byte;

    spi_mem_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cs_s),
        .bit_stb (sclk_rise),
        .bit_val (mosi_s),
        .byte_stb(byte_done),
        .byte_val(rx_byte),
        .at_bound(at_bound)
    );

    mem_state_t     state, nxt;
    logic           wel, frame_wr;
    logic [1:0]     addr_left;
    logic [ACW-1:0] acc, nxt_acc;
    logic [AW-1:0]  ptr;
    logic [7:0]     tx, rd_data;
    logic           wr_en;
    logic [7:0]     op_base;
    logic           is_arm, is_wr, is_rd;

    spi_mem_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
        .clk  (clk),
        .we   (wr_en),
        .waddr(ptr),
        .wdata(rx_byte),
        .raddr(ptr),
        .rdata(rd_data)
    );

    // opcode decode
    assign op_base = NINE_BIT ? (rx_byte & ~OP_HIBIT) : rx_byte;
    assign is_arm  = (rx_byte == OP_ARM);
    assign is_wr   = (op_base == OP_STORE);
    assign is_rd   = (op_base == OP_FETCH);
    assign nxt_acc = {acc[ACW-9:0], rx_byte};

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        if (is_arm)              nxt = ST_WREN;
                        else if (is_wr || is_rd) nxt = ST_ADDR;
                        else                     nxt = ST_SKIP;
                    end
                end
                ST_WREN:  if (sclk_rise) nxt = ST_SKIP;
                ST_ADDR: begin
                    if (byte_done && addr_left == 2'd0)
                        nxt = frame_wr ? ST_WDATA : ST_RDATA;
                end
                ST_WDATA: nxt = ST_WDATA;
                ST_RDATA: nxt = ST_RDATA;
                ST_SKIP:  nxt = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            frame_wr  <= 1'b0;
            addr_left <= '0;
            acc       <= '0;
            ptr       <= '0;
            tx        <= '0;
        end else begin
            if (cs_rise) begin
                if (state == ST_WREN) wel <= 1'b1;
                else if (frame_wr)    wel <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    frame_wr <= 1'b0;
                    tx       <= '0;
                end
                ST_CMD: begin
                    if (byte_done) begin
                        frame_wr  <= is_wr;
                        acc       <= NINE_BIT ? ACW'(rx_byte[3]) : '0;
                        addr_left <= 2'(NADDR - 1);
                    end
                end
                ST_ADDR: begin
                    if (byte_done) begin
                        acc       <= nxt_acc;
                        addr_left <= addr_left - 2'd1;
                        if (addr_left == 2'd0) ptr <= nxt_acc[AW-1:0];
                    end
                end
                ST_WDATA: begin
                    if (byte_done) ptr <= ptr + 1'b1;
                end
                ST_RDATA: begin
                    if (sclk_fall) begin
                        if (at_bound) begin
                            tx  <= rd_data;
                            ptr <= ptr + 1'b1;
                        end else begin
                            tx <= {tx[6:0], 1'b0};
                        end
                    end
                end
                ST_WREN, ST_SKIP: ;
            endcase
        end
    end

    assign wr_en = (state == ST_WDATA) && byte_done && wel;
    assign miso  = (state == ST_RDATA) ? tx[7] : 1'b0;

    logic unused_bits;
    assign unused_bits = &{1'b0, s_v[0], fall_v[2:1], rise_v[1], acc[ACW-1], nxt_acc};

endmodule

// File: rtl/spi_mem_checker.sv
module spi_mem_checker
    import spi_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso,
    input mem_state_t state,
    input logic       wel,
    input logic       frame_wr
);

    AST_MISO_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !miso); // R10

    AST_ARM_FROM_LONE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(state) == ST_WREN); // R2

    AST_DISARM_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> $past(frame_wr)); // R4

    AST_ARM_EXTRA_BITS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WREN |=> (state == ST_WREN || state == ST_SKIP || state == ST_IDLE)); // R3

    AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP |=> (state == ST_SKIP || state == ST_IDLE)); // R9

    AST_READ_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RDATA |=> (state == ST_RDATA || state == ST_IDLE)); // R5

endmodule

bind spi_mem_model spi_mem_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .miso    (miso),
    .state   (state),
    .wel     (wel),
    .frame_wr(frame_wr)
);

// File: tb/test_spi_mem_model.sv
`timescale 1ns/1ps
module test_spi_mem_model;

    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_a = 1'b1, cs_b = 1'b1;
    logic miso_a, miso_b;
    bit   selb = 1'b0;
    int   checks = 0, errors = 0;
    logic [7:0] expA [512];
    logic [7:0] expB [256];

    always #2 clk = ~clk;

    spi_mem_model i_spi_mem_model (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_a), .miso(miso_a)
    );

    spi_mem_model #(.MEM_BYTES(256), .ADDR_BYTES(2), .NINE_BIT(1'b0)) i_spi_mem_model_mb (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_b), .miso(miso_b)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(a * 37 + 11) ^ ((a >= 256) ? 8'h80 : 8'h00);
    endfunction

    function automatic logic [7:0] expv(int idx);
        return selb ? expB[idx % 256] : expA[idx % 512];
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic xb(input logic [7:0] t, output logic [7:0] r, input bit fast_end);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            tick(H);
            r[i] = selb ? miso_b : miso_a;
            sclk = 1'b1;
            if (fast_end && i == 0) begin
                tick(1);
                cs_a = 1'b1;
                cs_b = 1'b1;
            end
            tick(H);
            sclk = 1'b0;
        end
    endtask

    task automatic fbeg();
        if (selb) cs_b = 1'b0; else cs_a = 1'b0;
        tick(H);
    endtask

    task automatic fend();
        tick(H);
        cs_a = 1'b1;
        cs_b = 1'b1;
        tick(2 * H);
    endtask

    // command and address bytes: output must stay 0 (R10)
    task automatic send(string req, logic [7:0] b);
        logic [7:0] r;
        xb(b, r, 1'b0);
        check(req, r, 8'h00);
    endtask

    task automatic arm();
        fbeg(); send("R10", 8'h06); fend();
    endtask

    task automatic rd_run(string req, int start, int n);
        logic [7:0] r;
        for (int i = 0; i < n; i++) begin
            xb(8'h00, r, 1'b0);
            check(req, r, expv(start + i));
        end
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1 / R10: output idle after reset with select high
        check("R1", {7'd0, miso_a}, 8'h00);
        check("R10", {7'd0, miso_b}, 8'h00);

        // R2: arm then fill the whole array with one frame
        arm();
        fbeg(); send("R10", 8'h02); send("R10", 8'h00);
        for (int a = 0; a < 512; a++) begin
            send("R2", pat(a));
            expA[a] = pat(a);
        end
        fend();

        // R5: low half with 0x03, R6: high half with 0x0B
        fbeg(); send("R10", 8'h03); send("R10", 8'h00); rd_run("R5", 0, 256); fend();
        fbeg(); send("R10", 8'h0B); send("R10", 8'h00); rd_run("R6", 256, 256); fend();

        // R4: latch was cleared by the previous write frame
        fbeg(); send("R4", 8'h02); send("R4", 8'h20); send("R4", 8'h00); fend();
        fbeg(); send("R10", 8'h03); send("R10", 8'h20); rd_run("R4", 32'h20, 1); fend();

        // R3: write-enable with trailing bits does not arm
        fbeg(); send("R3", 8'h06); send("R3", 8'h00); fend();
        fbeg(); send("R3", 8'h0A); send("R3", 8'h30); send("R3", 8'hEE); fend();
        fbeg(); send("R10", 8'h0B); send("R10", 8'h30); rd_run("R3", 32'h130, 1); fend();

        // R8: wrap across 0x1FF -> 0x000, last byte ends with early select rise
        arm();
        begin
            logic [7:0] r;
            fbeg(); send("R10", 8'h0A); send("R10", 8'hFE);
            send("R8", 8'hD0); send("R8", 8'hD1); send("R8", 8'hD2);
            xb(8'hD3, r, 1'b1);
            check("R8", r, 8'h00);
            tick(2 * H);
        end
        expA[510] = 8'hD0; expA[511] = 8'hD1; expA[0] = 8'hD2; expA[1] = 8'hD3;
        fbeg(); send("R10", 8'h0B); send("R10", 8'hFE); rd_run("R8", 510, 4); fend();
        // R4: same-cycle store and latch clear left the latch clear
        fbeg(); send("R4", 8'h02); send("R4", 8'h00); send("R4", 8'h99); fend();
        fbeg(); send("R10", 8'h03); send("R10", 8'h00); rd_run("R4", 0, 2); fend();

        // R9: unknown opcode with latch armed
        arm();
        fbeg(); send("R9", 8'h01); send("R9", 8'h40); send("R9", 8'h77); send("R9", 8'hFF); fend();
        fbeg(); send("R10", 8'h03); send("R10", 8'h40); rd_run("R9", 32'h40, 1); fend();

        // R1: reset clears the latch, memory keeps its contents
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(4);
        check("R1", {7'd0, miso_a}, 8'h00);
        fbeg(); send("R1", 8'h02); send("R1", 8'h10); send("R1", 8'hAA); fend();
        fbeg(); send("R10", 8'h03); send("R10", 8'h10); rd_run("R1", 32'h10, 1); fend();

        // wide-address instance
        selb = 1'b1;
        // R7: MSB-first address, reduced modulo 256
        arm();
        fbeg(); send("R10", 8'h02); send("R10", 8'h00); send("R10", 8'h80); send("R7", 8'hC3); fend();
        expB[8'h80] = 8'hC3;
        arm();
        fbeg(); send("R10", 8'h02); send("R10", 8'h80); send("R10", 8'h00); send("R7", 8'h3C); fend();
        expB[0] = 8'h3C;
        fbeg(); send("R10", 8'h03); send("R10", 8'h00); send("R10", 8'h80); rd_run("R7", 8'h80, 1); fend();
        fbeg(); send("R10", 8'h03); send("R10", 8'h80); send("R10", 8'h00); rd_run("R7", 0, 1); fend();
        fbeg(); send("R10", 8'h03); send("R10", 8'h12); send("R10", 8'h80); rd_run("R7", 8'h80, 1); fend();

        // R8: wrap from 0xFF to 0x00
        arm();
        fbeg(); send("R10", 8'h02); send("R10", 8'h00); send("R10", 8'hFF);
        send("R8", 8'h11); send("R8", 8'h22); fend();
        expB[255] = 8'h11; expB[0] = 8'h22;
        fbeg(); send("R10", 8'h03); send("R10", 8'h00); send("R10", 8'hFF); rd_run("R8", 255, 2); fend();

        // R9: 0x0A is unknown in wide mode
        arm();
        fbeg(); send("R9", 8'h0A); send("R9", 8'h00); send("R9", 8'h00); send("R9", 8'h99); fend();
        fbeg(); send("R10", 8'h03); send("R10", 8'h00); send("R10", 8'h00); rd_run("R9", 0, 1); fend();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule